// File: doc/BRIEF.md
# NOR Flash Toggle-Bit Completion Poller

This block decides when an embedded program or erase inside a parallel NOR flash has finished. Once it gets a start pulse carrying a status address and a cycle budget, it asks a bus sequencer for status reads from that address, two at a time. A pair is judged by comparing the toggle flag (bit 6) of the two words. The fault flag (bit 5) of the first word of the pair decides whether a toggling result gets a confirming second look or a fresh pair.

The outcome is success, error or timeout. A one-cycle done pulse marks it, and the result stays on the output until the next accepted start. A cycle counter begins at the start pulse and keeps running across every pair. When it passes the budget, the poll ends with a timeout. A budget of zero ends the poll at once, with no read issued.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset, done_o, busy_o and rd_req_o are low and result_o is 00 (none).
- R2: A start accepted while idle latches addr_i. Every read request is made at that address. rd_req_o stays high until rd_ack_i, and rd_data_i is taken in the cycle rd_ack_i is high.
- R3: If bit 6 of the two words of a pair is equal, the poll ends with result 01 (success).
- R4: If bit 6 differs and bit 5 of the pair's first word is set, a confirming pair is read. If bit 6 of the confirming pair is equal, the result is 01 (success).
- R5: If bit 6 still differs in the confirming pair and bit 5 of its first word is set, the result is 10 (error).
- R6: If bit 6 differs and bit 5 of the first word is clear, in either pass, polling restarts with a new first-pass pair.
- R7: A start with timeout_i equal to zero gives result 11 (timeout) with done_o on the cycle after the start, and issues no read.
- R8: The cycle counter is cleared at the start and counts every busy cycle across all pairs. When the counter exceeds timeout_i, the poll ends with result 11, abandoning any outstanding read. With k counted from the start edge, this is at edge k = timeout+2. If the limit is reached on the same edge as a verdict, timeout wins.
- R9: done_o is high for exactly one cycle. result_o holds its value until the next accepted start, which clears it to 00.
- R10: A start pulse while busy is ignored. The address, the budget and the counter are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a poll (taken only when idle) |
| addr_i | input | ADDR_W | Status address to poll |
| timeout_i | input | TMO_W | Cycle budget; zero means immediate timeout |
| rd_req_o | output | 1 | Status read request to bus sequencer |
| rd_addr_o | output | ADDR_W | Address of the requested read |
| rd_ack_i | input | 1 | Read completes this cycle |
| rd_data_i | input | DATA_W | Status word returned with rd_ack_i |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle end-of-poll pulse |
| result_o | output | 2 | 00 none, 01 success, 10 error, 11 timeout |

## Verification
The hardest case to reach is a timeout that lands on the same edge as a verdict, because the counter value and the pair timing must line up exactly. The bench acknowledges every request on the cycle it is raised, so each pair takes two cycles. It sends a restart pair followed by a settled pair with budgets of 2 and 3. With a budget of 2 the expiry and the success verdict fall on edge 4 and the result must be timeout; with a budget of 3 the same words give success. The confirm-then-restart path also needs a scripted word sequence: a first-pass toggle with bit 5 set, then a confirming toggle with bit 5 clear.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;
  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_OK      = 2'b01,
    RES_FAIL    = 2'b10,
    RES_TIMEOUT = 2'b11
  } poll_res_t;

  typedef enum logic [1:0] {
    VD_OK,
    VD_CONFIRM,
    VD_FAIL,
    VD_AGAIN
  } verdict_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B
  } seq_state_t;
endpackage

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int CNT_W = TMO_W + 1;

  logic [TMO_W-1:0] limit_q, limit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    limit_d = limit_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      limit_d = limit_i;
      cnt_d   = '0;
    end else if (run_i && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else begin
      limit_q <= limit_d;
      cnt_q   <= cnt_d;
    end
  end

  assign expired_o = cnt_q > {1'b0, limit_q};
endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
  import nor_poll_pkg::*;
(
  input  logic     first_tog_i,
  input  logic     first_lim_i,
  input  logic     second_tog_i,
  input  logic     confirm_i,
  output verdict_t verdict_o
);
  always_comb begin
    if (first_tog_i == second_tog_i) begin
      verdict_o = VD_OK;
    end else if (first_lim_i) begin
      verdict_o = confirm_i ? VD_FAIL : VD_CONFIRM;
    end else begin
      verdict_o = VD_AGAIN;
    end
  end
endmodule

// File: rtl/nor_poll_seq.sv
module nor_poll_seq
  import nor_poll_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              zero_tmo_i,
  input  logic              expired_i,
  input  logic              rd_ack_i,
  input  logic              now_tog_i,
  input  logic              now_lim_i,
  input  verdict_t          verdict_i,
  output logic              first_tog_o,
  output logic              first_lim_o,
  output logic              confirm_o,
  output logic              load_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output poll_res_t         result_o
);
  seq_state_t        st_q, st_d;
  logic              pass_q, pass_d;
  logic [1:0]        samp_q, samp_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  poll_res_t         res_q, res_d;

  always_comb begin
    st_d   = st_q;
    pass_d = pass_q;
    samp_d = samp_q;
    addr_d = addr_q;
    done_d = 1'b0;
    res_d  = res_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          addr_d = addr_i;
          pass_d = 1'b0;
          if (zero_tmo_i) begin
            done_d = 1'b1;
            res_d  = RES_TIMEOUT;
          end else begin
            res_d = RES_NONE;
            st_d  = ST_RD_A;
          end
        end
      end
      ST_RD_A: begin
        if (expired_i) begin
          done_d = 1'b1;
          res_d  = RES_TIMEOUT;
          st_d   = ST_IDLE;
        end else if (rd_ack_i) begin
          samp_d = {now_lim_i, now_tog_i};
          st_d   = ST_RD_B;
        end
      end
      ST_RD_B: begin
        if (expired_i) begin
          done_d = 1'b1;
          res_d  = RES_TIMEOUT;
          st_d   = ST_IDLE;
        end else if (rd_ack_i) begin
          unique case (verdict_i)
            VD_OK: begin
              done_d = 1'b1;
              res_d  = RES_OK;
              st_d   = ST_IDLE;
            end
            VD_FAIL: begin
              done_d = 1'b1;
              res_d  = RES_FAIL;
              st_d   = ST_IDLE;
            end
            VD_CONFIRM: begin
              pass_d = 1'b1;
              st_d   = ST_RD_A;
            end
            default: begin
              pass_d = 1'b0;
              st_d   = ST_RD_A;
            end
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      samp_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      res_q  <= RES_NONE;
    end else begin
      st_q   <= st_d;
      pass_q <= pass_d;
      samp_q <= samp_d;
      addr_q <= addr_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign first_tog_o = samp_q[0];
  assign first_lim_o = samp_q[1];
  assign confirm_o   = pass_q;
  assign rd_req_o    = st_q != ST_IDLE;
  assign busy_o      = st_q != ST_IDLE;
  assign rd_addr_o   = addr_q;
  assign done_o      = done_q;
  assign result_o    = res_q;
endmodule

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller
  import nor_poll_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int TMO_W   = 20,
  parameter int TOG_BIT = 6,
  parameter int LIM_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o
);
  logic      expired, load, first_tog, first_lim, confirm, zero_tmo;
  logic      unused_status_bits;
  verdict_t  verdict;
  poll_res_t res;

  assign zero_tmo           = timeout_i == '0;
  assign unused_status_bits = ^rd_data_i;

  nor_poll_timer #(.TMO_W(TMO_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .run_i     (busy_o),
    .limit_i   (timeout_i),
    .expired_o (expired)
  );

  nor_poll_judge judge_i (
    .first_tog_i  (first_tog),
    .first_lim_i  (first_lim),
    .second_tog_i (rd_data_i[TOG_BIT]),
    .confirm_i    (confirm),
    .verdict_o    (verdict)
  );

  nor_poll_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .zero_tmo_i  (zero_tmo),
    .expired_i   (expired),
    .rd_ack_i    (rd_ack_i),
    .now_tog_i   (rd_data_i[TOG_BIT]),
    .now_lim_i   (rd_data_i[LIM_BIT]),
    .verdict_i   (verdict),
    .first_tog_o (first_tog),
    .first_lim_o (first_lim),
    .confirm_o   (confirm),
    .load_o      (load),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (res)
  );

  assign result_o = res;
endmodule

// File: rtl/nor_poll_checker.sv
module nor_poll_checker #(
  parameter int ADDR_W = 24,
  parameter int TMO_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [TMO_W-1:0]  timeout_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        result_o
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != 2'b00));

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(result_o));

  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));

  a_r7_zero_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (timeout_i == '0)) |=> (done_o && result_o == 2'b11 && !busy_o));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind nor_toggle_poller nor_poll_checker #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .timeout_i (timeout_i),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ack_i  (rd_ack_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/nor_toggle_poller_tb_top.sv
`timescale 1ns/1ps
module nor_toggle_poller_tb_top;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] addr_i;
  logic [TW-1:0] timeout_i;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i;
  logic [DW-1:0] rd_data_i;
  logic          busy_o;
  logic          done_o;
  logic [1:0]    result_o;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] resp [16];
  int            resp_n;
  int            resp_idx;
  bit            ack_en;
  logic [AW-1:0] exp_addr;
  int            addr_err;

  always #10 clk = ~clk;

  nor_toggle_poller #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .timeout_i(timeout_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  // status responder: answers a pending request in the same cycle
  always @(negedge clk) begin
    if (ack_en && rd_req_o && resp_idx < resp_n) begin
      rd_ack_i  <= 1'b1;
      rd_data_i <= resp[resp_idx];
      resp_idx  <= resp_idx + 1;
      if (rd_addr_o != exp_addr) addr_err <= addr_err + 1;
    end else begin
      rd_ack_i  <= 1'b0;
      rd_data_i <= '0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic load_words(input logic [DW-1:0] w [], input bit en);
    for (int i = 0; i < 16; i++) resp[i] = (i < w.size()) ? w[i] : '0;
    resp_n   = w.size();
    resp_idx = 0;
    ack_en   = en;
    addr_err = 0;
  endtask

  task automatic pulse_start(input logic [AW-1:0] a, input logic [TW-1:0] t);
    @(negedge clk);
    start_i   = 1'b1;
    addr_i    = a;
    timeout_i = t;
    exp_addr  = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_case(input string req, input logic [DW-1:0] w [],
                          input bit en, input logic [TW-1:0] t,
                          input int exp_n, input logic [1:0] exp_res);
    int n;
    load_words(w, en);
    pulse_start(24'h00A5C0 + total, t);
    wait_done(n);
    chk(n == exp_n, {req, " done edge"}, n, exp_n);
    chk(result_o == exp_res, {req, " result"}, result_o, exp_res);
    chk(addr_err == 0, {req, " R2 read address"}, addr_err, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!done_o && !busy_o && !rd_req_o, "R1 control outputs", {done_o, busy_o, rd_req_o}, 0);
    chk(result_o == 2'b00, "R1 result", result_o, 0);
  endtask

  task automatic t_zero_budget();
    int n;
    load_words('{16'h0040, 16'h0000}, 1'b1);
    pulse_start(24'h000100, '0);
    wait_done(n);
    chk(n == 0 && result_o == 2'b11, "R7 immediate timeout", {n[7:0], 6'd0, result_o}, 16'h0003);
    chk(!rd_req_o && !busy_o && resp_idx == 0, "R7 no read", resp_idx, 0);
    @(negedge clk);
  endtask

  task automatic t_hold_and_clear();
    int n;
    load_words('{16'h0000, 16'h0000}, 1'b1);
    pulse_start(24'h000200, 20'd50);
    wait_done(n);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);
    repeat (5) @(negedge clk);
    chk(result_o == 2'b01, "R9 result held", result_o, 1);
    load_words('{16'h0040, 16'h0000}, 1'b0);
    pulse_start(24'h000300, 20'd50);
    chk(result_o == 2'b00 && busy_o, "R9 start clears result", result_o, 0);
    wait_done(n);
    @(negedge clk);
  endtask

  task automatic t_busy_start();
    int n;
    load_words('{16'h0000}, 1'b0);
    pulse_start(24'h000400, 20'd6);
    repeat (2) @(negedge clk);
    start_i   = 1'b1;
    addr_i    = 24'h0FFFFF;
    timeout_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    n = 3;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == 8, "R10 budget kept", n, 8);
    chk(result_o == 2'b11, "R10 result", result_o, 3);
    chk(rd_addr_o == 24'h000400, "R10 address kept", rd_addr_o, 24'h000400);
    @(negedge clk);
  endtask

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    addr_i    = '0;
    timeout_i = '0;
    rd_ack_i  = 1'b0;
    rd_data_i = '0;
    ack_en    = 1'b0;
    resp_n    = 0;
    resp_idx  = 0;
    exp_addr  = '0;
    addr_err  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R3 settled pair", '{16'h0080, 16'h0080}, 1'b1, 20'd100, 2, 2'b01);
    run_case("R4 confirm then settled", '{16'h0060, 16'h0020, 16'h0040, 16'h0040}, 1'b1, 20'd100, 4, 2'b01);
    run_case("R5 confirm still toggling", '{16'h0060, 16'h0020, 16'h0020, 16'h0060}, 1'b1, 20'd100, 4, 2'b10);
    run_case("R6 restart paths",
             '{16'h0040, 16'h0000, 16'h0060, 16'h0020, 16'h0000, 16'h0040, 16'h0011, 16'h0011},
             1'b1, 20'd100, 8, 2'b01);
    t_zero_budget();
    run_case("R8 no acknowledge", '{16'h0000}, 1'b0, 20'd10, 12, 2'b11);
    run_case("R8 across iterations",
             '{16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000,
               16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0000},
             1'b1, 20'd7, 9, 2'b11);
    run_case("R8 tie goes to timeout", '{16'h0040, 16'h0000, 16'h0010, 16'h0010}, 1'b1, 20'd2, 4, 2'b11);
    run_case("R8 one cycle spare", '{16'h0040, 16'h0000, 16'h0010, 16'h0010}, 1'b1, 20'd3, 4, 2'b01);
    t_hold_and_clear();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule